// File: doc/BRIEF.md
# Exception and Interrupt Entry Controller

This block sits beside the fetch unit of a small 32-bit processor with two banks of low general registers. It decides when the processor leaves normal flow for a synchronous exception or an external interrupt, and when it comes back. On entry it captures the status word, a return address and the stack pointer (R15) into shadow registers and records the event code. It then raises the status word into privileged, blocked, alternate-bank mode and sends fetch a one-cycle redirect to an address built from the vector base.

A return command reloads the status word from its shadow copy at once. The jump back to the saved address waits until the following instruction, the delay slot, has retired. Every change of the bank-select bit, whatever its cause, produces a one-cycle swap pulse for the register file. An exception raised while the vector base is still zero stops the block for good, in place of a jump through an unset table.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While reset is held, the status word reads 0x700000F0, the vector base reads 0 and the FP control word reads 0x00040001. On the first clock edge after reset, redirect_o pulses with target 0xA0000000 and next address 0xA0000002.
- R2: An accepted exception stores pc_i+2 in the saved-PC register, the prior status word in the saved-status register, r15_i in the saved-stack register and exc_code_i in the exception-event register. The codes in use are 0x180 (illegal instruction), 0x1A0 (illegal in delay slot), 0x160 (trap) and 0x800 (FPU off), all with offset 0x100.
- R3: On any entry the new status word is the prior word with bits 30 (privileged), 29 (bank select) and 28 (block) set.
- R4: Entry issues a single-cycle redirect to vector base + offset, with next address target+2. entry_o and busy_o are high in that same cycle, and any request present during that cycle is ignored.
- R5: An accepted interrupt stores pc_i (the unexecuted instruction) as the saved PC, irq_code_i in the interrupt-event register, pulses irq_ack_o and redirects to vector base + 0x600.
- R6: An interrupt is taken only when boundary_i is 1, in_slot_i is 0 and status bit 28 is 0. A simultaneous exception wins, and irq_ack_o stays low.
- R7: bank_swap_o pulses for one cycle exactly when status bit 29 changes, whether by entry, return or a direct write.
- R8: rte_i loads the saved status word in the next cycle without redirecting. The next step_i then redirects to the saved PC, with next address saved PC + 2.
- R9: An exception request while the vector base is 0 sets halt_o permanently, saves nothing and does not redirect. After that every request and register write is ignored.
- R10: vbr_wr_i and fpscr_wr_i load their data on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| pc_i | input | 32 | Address of the instruction at the head of execution |
| r15_i | input | 32 | Current stack pointer |
| boundary_i | input | 1 | Execution is at an instruction boundary |
| in_slot_i | input | 1 | Current instruction is a delay slot |
| step_i | input | 1 | An instruction retired this cycle |
| exc_req_i | input | 1 | Synchronous exception request |
| exc_code_i | input | 12 | Exception event code |
| exc_off_i | input | 12 | Exception vector offset |
| irq_req_i | input | 1 | Pending interrupt |
| irq_code_i | input | 12 | Interrupt event code |
| rte_i | input | 1 | Return-from-exception command |
| sr_wr_i | input | 1 | Status word write |
| sr_wdata_i | input | 32 | Status word write data |
| vbr_wr_i | input | 1 | Vector base write |
| vbr_wdata_i | input | 32 | Vector base write data |
| fpscr_wr_i | input | 1 | FP control word write |
| fpscr_wdata_i | input | 32 | FP control word write data |
| redirect_o | output | 1 | One-cycle fetch redirect |
| redirect_pc_o | output | 32 | Redirect target |
| next_pc_o | output | 32 | Address after the target |
| entry_o | output | 1 | Redirect is an exception or interrupt entry |
| irq_ack_o | output | 1 | Interrupt accepted |
| busy_o | output | 1 | Fetch must stall |
| halt_o | output | 1 | Fatal stop, vector base unset |
| bank_swap_o | output | 1 | Swap low registers with bank |
| sr_o | output | 32 | Status word |
| ssr_o | output | 32 | Saved status word |
| spc_o | output | 32 | Saved PC |
| sgr_o | output | 32 | Saved stack pointer |
| vbr_o | output | 32 | Vector base |
| fpscr_o | output | 32 | FP control word |
| exc_event_o | output | 12 | Last exception code |
| irq_event_o | output | 12 | Last interrupt code |

## Verification
The return path is the hardest case to reach. The saved status and saved PC only hold meaningful values after a real interrupt entry, and the jump back must be held off until a separate retire strobe arrives. The stimulus therefore opens the block up by writing the status word with the block bit clear. It then offers interrupts that must be refused (off-boundary, in a slot) before one that is taken, issues the return, checks that the status word is restored with no redirect, and only then sends the retire strobe. The permanent stop is exercised last, since only reset leaves it.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int DW = 32;
  localparam int CW = 12;
  localparam int SR_BL = 28;
  localparam int SR_RB = 29;
  localparam int SR_MD = 30;
  localparam logic [CW-1:0] OFF_IRQ = 12'h600;
  localparam logic [DW-1:0] INSN_STEP = 32'd2;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_BOOT,
    RD_EXC,
    RD_IRQ,
    RD_RET
  } rd_src_e;

  // status word on entry: privileged, blocked, alternate bank
  function automatic logic [DW-1:0] entry_sr(input logic [DW-1:0] s);
    logic [DW-1:0] force_bits;
    force_bits = '0;
    force_bits[SR_MD] = 1'b1;
    force_bits[SR_RB] = 1'b1;
    force_bits[SR_BL] = 1'b1;
    return s | force_bits;
  endfunction

  function automatic logic [DW-1:0] vector_addr(input logic [DW-1:0] base,
                                                input logic [CW-1:0] off);
    return base + DW'(off);
  endfunction

  function automatic logic [DW-1:0] after_insn(input logic [DW-1:0] a);
    return a + INSN_STEP;
  endfunction
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter (
  input  logic hold_i,
  input  logic exc_req_i,
  input  logic vbr_zero_i,
  input  logic irq_req_i,
  input  logic boundary_i,
  input  logic in_slot_i,
  input  logic sr_bl_i,
  input  logic rte_req_i,
  input  logic rte_pend_i,
  input  logic step_i,
  output logic take_exc_o,
  output logic take_halt_o,
  output logic take_irq_o,
  output logic take_rte_o,
  output logic ret_done_o
);
  logic irq_ok;

  always_comb begin
    irq_ok      = irq_req_i & boundary_i & ~in_slot_i & ~sr_bl_i;
    take_exc_o  = ~hold_i & exc_req_i & ~vbr_zero_i;
    take_halt_o = ~hold_i & exc_req_i & vbr_zero_i;
    ret_done_o  = ~hold_i & ~exc_req_i & rte_pend_i & step_i;
    take_irq_o  = ~hold_i & ~exc_req_i & ~ret_done_o & irq_ok;
    take_rte_o  = ~hold_i & ~exc_req_i & ~ret_done_o & ~irq_ok & rte_req_i;
  end
endmodule

// File: rtl/exc_shadow.sv
module exc_shadow
  import exc_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          take_exc_i,
  input  logic          take_irq_i,
  input  logic [DW-1:0] pc_i,
  input  logic [DW-1:0] sr_i,
  input  logic [DW-1:0] r15_i,
  input  logic [CW-1:0] exc_code_i,
  input  logic [CW-1:0] irq_code_i,
  output logic [DW-1:0] spc_o,
  output logic [DW-1:0] ssr_o,
  output logic [DW-1:0] sgr_o,
  output logic [CW-1:0] exc_event_o,
  output logic [CW-1:0] irq_event_o
);
  logic save;
  assign save = take_exc_i | take_irq_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      spc_o       <= '0;
      ssr_o       <= '0;
      sgr_o       <= '0;
      exc_event_o <= '0;
      irq_event_o <= '0;
    end else begin
      if (save) begin
        // exception resumes past the faulting word, interrupt re-runs pc_i
        spc_o <= take_exc_i ? after_insn(pc_i) : pc_i;
        ssr_o <= sr_i;
        sgr_o <= r15_i;
      end
      if (take_exc_i) exc_event_o <= exc_code_i;
      if (take_irq_i) irq_event_o <= irq_code_i;
    end
  end
endmodule

// File: rtl/exc_redirect.sv
module exc_redirect
  import exc_pkg::*;
#(
  parameter logic [DW-1:0] BOOT_PC = 32'hA000_0000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          boot_i,
  input  logic          take_exc_i,
  input  logic          take_irq_i,
  input  logic          ret_done_i,
  input  logic [DW-1:0] vbr_i,
  input  logic [CW-1:0] exc_off_i,
  input  logic [DW-1:0] spc_i,
  output logic          redirect_o,
  output logic [DW-1:0] target_o,
  output logic [DW-1:0] next_o,
  output logic          entry_o,
  output logic          irq_ack_o
);
  rd_src_e       src;
  logic [DW-1:0] tgt;

  always_comb begin
    if (boot_i)          src = RD_BOOT;
    else if (take_exc_i) src = RD_EXC;
    else if (take_irq_i) src = RD_IRQ;
    else if (ret_done_i) src = RD_RET;
    else                 src = RD_NONE;
    case (src)
      RD_BOOT: tgt = BOOT_PC;
      RD_EXC:  tgt = vector_addr(vbr_i, exc_off_i);
      RD_IRQ:  tgt = vector_addr(vbr_i, OFF_IRQ);
      RD_RET:  tgt = spc_i;
      default: tgt = target_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redirect_o <= 1'b0;
      target_o   <= '0;
      next_o     <= '0;
      entry_o    <= 1'b0;
      irq_ack_o  <= 1'b0;
    end else begin
      redirect_o <= (src != RD_NONE);
      entry_o    <= (src == RD_EXC) || (src == RD_IRQ);
      irq_ack_o  <= (src == RD_IRQ);
      if (src != RD_NONE) begin
        target_o <= tgt;
        next_o   <= after_insn(tgt);
      end
    end
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter logic [DW-1:0] RESET_PC    = 32'hA000_0000,
  parameter logic [DW-1:0] SR_RESET    = 32'h7000_00F0,
  parameter logic [DW-1:0] FPSCR_RESET = 32'h0004_0001
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] pc_i,
  input  logic [DW-1:0] r15_i,
  input  logic          boundary_i,
  input  logic          in_slot_i,
  input  logic          step_i,
  input  logic          exc_req_i,
  input  logic [CW-1:0] exc_code_i,
  input  logic [CW-1:0] exc_off_i,
  input  logic          irq_req_i,
  input  logic [CW-1:0] irq_code_i,
  input  logic          rte_i,
  input  logic          sr_wr_i,
  input  logic [DW-1:0] sr_wdata_i,
  input  logic          vbr_wr_i,
  input  logic [DW-1:0] vbr_wdata_i,
  input  logic          fpscr_wr_i,
  input  logic [DW-1:0] fpscr_wdata_i,
  output logic          redirect_o,
  output logic [DW-1:0] redirect_pc_o,
  output logic [DW-1:0] next_pc_o,
  output logic          entry_o,
  output logic          irq_ack_o,
  output logic          busy_o,
  output logic          halt_o,
  output logic          bank_swap_o,
  output logic [DW-1:0] sr_o,
  output logic [DW-1:0] ssr_o,
  output logic [DW-1:0] spc_o,
  output logic [DW-1:0] sgr_o,
  output logic [DW-1:0] vbr_o,
  output logic [DW-1:0] fpscr_o,
  output logic [CW-1:0] exc_event_o,
  output logic [CW-1:0] irq_event_o
);
  logic [DW-1:0] sr_q, sr_d, vbr_q, fpscr_q;
  logic          halt_q, boot_q, rte_pend_q, swap_q;
  logic          hold, vbr_zero;
  logic          take_exc, take_halt, take_irq, take_rte, ret_done;

  assign hold     = boot_q | redirect_o | halt_q;
  assign vbr_zero = (vbr_q == '0);

  exc_arbiter u_arb (
    .hold_i      (hold),
    .exc_req_i   (exc_req_i),
    .vbr_zero_i  (vbr_zero),
    .irq_req_i   (irq_req_i),
    .boundary_i  (boundary_i),
    .in_slot_i   (in_slot_i),
    .sr_bl_i     (sr_q[SR_BL]),
    .rte_req_i   (rte_i),
    .rte_pend_i  (rte_pend_q),
    .step_i      (step_i),
    .take_exc_o  (take_exc),
    .take_halt_o (take_halt),
    .take_irq_o  (take_irq),
    .take_rte_o  (take_rte),
    .ret_done_o  (ret_done)
  );

  exc_shadow u_shadow (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .take_exc_i  (take_exc),
    .take_irq_i  (take_irq),
    .pc_i        (pc_i),
    .sr_i        (sr_q),
    .r15_i       (r15_i),
    .exc_code_i  (exc_code_i),
    .irq_code_i  (irq_code_i),
    .spc_o       (spc_o),
    .ssr_o       (ssr_o),
    .sgr_o       (sgr_o),
    .exc_event_o (exc_event_o),
    .irq_event_o (irq_event_o)
  );

  exc_redirect #(.BOOT_PC(RESET_PC)) u_redir (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .boot_i     (boot_q),
    .take_exc_i (take_exc),
    .take_irq_i (take_irq),
    .ret_done_i (ret_done),
    .vbr_i      (vbr_q),
    .exc_off_i  (exc_off_i),
    .spc_i      (spc_o),
    .redirect_o (redirect_o),
    .target_o   (redirect_pc_o),
    .next_o     (next_pc_o),
    .entry_o    (entry_o),
    .irq_ack_o  (irq_ack_o)
  );

  // status word: entry beats return beats a direct write
  always_comb begin
    if (take_exc || take_irq)    sr_d = entry_sr(sr_q);
    else if (take_rte)           sr_d = ssr_o;
    else if (sr_wr_i && !halt_q) sr_d = sr_wdata_i;
    else                         sr_d = sr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q       <= SR_RESET;
      vbr_q      <= '0;
      fpscr_q    <= FPSCR_RESET;
      halt_q     <= 1'b0;
      boot_q     <= 1'b1;
      rte_pend_q <= 1'b0;
      swap_q     <= 1'b0;
    end else begin
      sr_q   <= sr_d;
      swap_q <= sr_d[SR_RB] ^ sr_q[SR_RB];
      boot_q <= 1'b0;
      if (take_halt) halt_q <= 1'b1;
      if (vbr_wr_i && !halt_q)   vbr_q   <= vbr_wdata_i;
      if (fpscr_wr_i && !halt_q) fpscr_q <= fpscr_wdata_i;
      if (take_exc || take_irq || ret_done) rte_pend_q <= 1'b0;
      else if (take_rte)                    rte_pend_q <= 1'b1;
    end
  end

  assign busy_o      = redirect_o | halt_q;
  assign halt_o      = halt_q;
  assign bank_swap_o = swap_q;
  assign sr_o        = sr_q;
  assign vbr_o       = vbr_q;
  assign fpscr_o     = fpscr_q;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        redirect_o,
  input logic [31:0] redirect_pc_o,
  input logic        entry_o,
  input logic        irq_ack_o,
  input logic        halt_o,
  input logic        bank_swap_o,
  input logic [31:0] sr_o,
  input logic [31:0] ssr_o,
  input logic [31:0] vbr_o
);
  p_entry_saves_sr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_o |-> ssr_o == $past(sr_o));

  p_entry_priv_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_o |-> (sr_o[30] && sr_o[29] && sr_o[28]));

  p_redirect_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |=> !redirect_o);

  p_irq_vector_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_o |-> redirect_pc_o == $past(vbr_o) + 32'h600);

  p_irq_unblocked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_o |-> !$past(sr_o[28]));

  p_swap_on_rb_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_swap_o |-> sr_o[29] != $past(sr_o[29]));

  p_halt_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> (halt_o && !redirect_o));
endmodule

bind exc_entry_ctrl exc_entry_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .redirect_o    (redirect_o),
  .redirect_pc_o (redirect_pc_o),
  .entry_o       (entry_o),
  .irq_ack_o     (irq_ack_o),
  .halt_o        (halt_o),
  .bank_swap_o   (bank_swap_o),
  .sr_o          (sr_o),
  .ssr_o         (ssr_o),
  .vbr_o         (vbr_o)
);

// File: tb/sim_exc_entry_ctrl.sv
`timescale 1ns/1ps
module sim_exc_entry_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] pc, r15, sr_wdata, vbr_wdata, fpscr_wdata;
  logic        boundary, in_slot, step, exc_req, irq_req, rte, sr_wr, vbr_wr, fpscr_wr;
  logic [11:0] exc_code, exc_off, irq_code;
  logic        redirect, entry, irq_ack, busy, halt, bank_swap;
  logic [31:0] redirect_pc, next_pc, sr, ssr, spc, sgr, vbr, fpscr;
  logic [11:0] exc_event, irq_event;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  exc_entry_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .pc_i(pc), .r15_i(r15), .boundary_i(boundary),
    .in_slot_i(in_slot), .step_i(step), .exc_req_i(exc_req), .exc_code_i(exc_code),
    .exc_off_i(exc_off), .irq_req_i(irq_req), .irq_code_i(irq_code), .rte_i(rte),
    .sr_wr_i(sr_wr), .sr_wdata_i(sr_wdata), .vbr_wr_i(vbr_wr), .vbr_wdata_i(vbr_wdata),
    .fpscr_wr_i(fpscr_wr), .fpscr_wdata_i(fpscr_wdata), .redirect_o(redirect),
    .redirect_pc_o(redirect_pc), .next_pc_o(next_pc), .entry_o(entry), .irq_ack_o(irq_ack),
    .busy_o(busy), .halt_o(halt), .bank_swap_o(bank_swap), .sr_o(sr), .ssr_o(ssr),
    .spc_o(spc), .sgr_o(sgr), .vbr_o(vbr), .fpscr_o(fpscr), .exc_event_o(exc_event),
    .irq_event_o(irq_event)
  );

  // row: {sr, code, offset, pc, r15, vbr}
  localparam logic [151:0] TBL [4] = '{
    {32'h0000_00F0, 12'h180, 12'h100, 32'h8C00_1000, 32'h8CFF_FF00, 32'h8C00_0000},
    {32'h2000_0010, 12'h1A0, 12'h100, 32'h0C00_00FE, 32'h1111_2222, 32'h8000_0000},
    {32'h4000_0001, 12'h160, 12'h100, 32'hFFFF_FFFE, 32'hDEAD_BEEF, 32'hFFFF_FF00},
    {32'h3000_0300, 12'h800, 12'h100, 32'h0000_1234, 32'h0000_0000, 32'h0001_0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    step = 0; exc_req = 0; irq_req = 0; rte = 0; sr_wr = 0; vbr_wr = 0; fpscr_wr = 0;
    boundary = 1; in_slot = 0;
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(20ns * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %08h expected %08h", 0, 1);
      finish_run();
    end
  end

  initial begin
    logic [31:0] hold_spc;
    pc = 0; r15 = 0; sr_wdata = 0; vbr_wdata = 0; fpscr_wdata = 0;
    exc_code = 0; exc_off = 0; irq_code = 0;
    clear_in();
    repeat (3) cyc();
    // R1 reset values
    chk("R1 sr", sr, 32'h7000_00F0);
    chk("R1 vbr", vbr, 0);
    chk("R1 fpscr", fpscr, 32'h0004_0001);
    chk("R1 redirect idle", {31'b0, redirect}, 0);
    rst_n = 1;
    cyc();
    chk("R1 boot redirect", {31'b0, redirect}, 1);
    chk("R1 boot pc", redirect_pc, 32'hA000_0000);
    chk("R1 boot next", next_pc, 32'hA000_0002);
    chk("R1 boot not entry", {31'b0, entry}, 0);
    cyc();
    chk("R4 boot pulse ends", {31'b0, redirect}, 0);

    // table of exception entries (R2 R3 R4 R7)
    for (int i = 0; i < 4; i++) begin
      logic [151:0] row;
      logic [31:0] exp_t;
      row = TBL[i];
      sr_wr = 1; sr_wdata = row[151:120]; vbr_wr = 1; vbr_wdata = row[31:0];
      cyc();
      clear_in();
      exc_req = 1; exc_code = row[119:108]; exc_off = row[107:96];
      pc = row[95:64]; r15 = row[63:32];
      cyc();
      exp_t = row[31:0] + {20'b0, row[107:96]};
      chk("R4 redirect", {31'b0, redirect}, 1);
      chk("R4 entry", {31'b0, entry}, 1);
      chk("R4 busy", {31'b0, busy}, 1);
      chk("R4 target", redirect_pc, exp_t);
      chk("R4 next", next_pc, exp_t + 2);
      chk("R2 spc", spc, row[95:64] + 2);
      chk("R2 ssr", ssr, row[151:120]);
      chk("R2 sgr", sgr, row[63:32]);
      chk("R2 event", {20'b0, exc_event}, {20'b0, row[119:108]});
      chk("R3 sr", sr, row[151:120] | 32'h7000_0000);
      chk("R7 swap on entry", {31'b0, bank_swap}, {31'b0, ~row[149]});
      pc = pc + 16;
      cyc();
      chk("R4 busy ignores", {31'b0, redirect}, 0);
      chk("R4 busy spc kept", spc, row[95:64] + 2);
      clear_in();
    end

    // R6 interrupt blocked by block bit (sr is 0x70000300)
    irq_req = 1; irq_code = 12'h3C0; pc = 32'h8C00_2000;
    cyc();
    chk("R6 blocked ack", {31'b0, irq_ack}, 0);
    chk("R6 blocked event", {20'b0, irq_event}, 0);
    clear_in();
    sr_wr = 1; sr_wdata = 32'h0000_00F0; vbr_wr = 1; vbr_wdata = 32'h8C00_0000;
    cyc();
    clear_in();
    irq_req = 1; boundary = 0;
    cyc();
    chk("R6 off boundary", {31'b0, irq_ack}, 0);
    boundary = 1; in_slot = 1;
    cyc();
    chk("R6 in slot", {31'b0, irq_ack}, 0);
    in_slot = 0; r15 = 32'h0BAD_F00D;
    cyc();
    chk("R5 ack", {31'b0, irq_ack}, 1);
    chk("R5 target", redirect_pc, 32'h8C00_0600);
    chk("R5 event", {20'b0, irq_event}, 32'h3C0);
    chk("R5 spc", spc, 32'h8C00_2000);
    chk("R5 ssr", ssr, 32'h0000_00F0);
    chk("R3 irq sr", sr, 32'h7000_00F0);
    chk("R7 irq swap", {31'b0, bank_swap}, 1);
    clear_in();
    cyc();

    // R8 return through delay slot
    rte = 1;
    cyc();
    clear_in();
    chk("R8 sr restored", sr, 32'h0000_00F0);
    chk("R8 no early redirect", {31'b0, redirect}, 0);
    chk("R7 rte swap", {31'b0, bank_swap}, 1);
    cyc();
    chk("R8 waits for slot", {31'b0, redirect}, 0);
    step = 1;
    cyc();
    clear_in();
    chk("R8 redirect", {31'b0, redirect}, 1);
    chk("R8 target", redirect_pc, 32'h8C00_2000);
    chk("R8 next", next_pc, 32'h8C00_2002);
    chk("R8 not entry", {31'b0, entry}, 0);
    cyc();

    // R6 exception wins over interrupt
    exc_req = 1; exc_code = 12'h160; exc_off = 12'h100; pc = 32'h8C00_3000;
    irq_req = 1; irq_code = 12'h2A0;
    cyc();
    clear_in();
    chk("R6 exc wins ack", {31'b0, irq_ack}, 0);
    chk("R6 exc wins target", redirect_pc, 32'h8C00_0100);
    chk("R6 exc wins event", {20'b0, exc_event}, 32'h160);
    chk("R6 irq event kept", {20'b0, irq_event}, 32'h3C0);
    cyc();

    // R7 write keeping bank bit set: no swap
    sr_wr = 1; sr_wdata = 32'h2000_0000;
    cyc();
    clear_in();
    chk("R7 no swap", {31'b0, bank_swap}, 0);
    chk("R7 sr written", sr, 32'h2000_0000);

    // R10 fp control write
    fpscr_wr = 1; fpscr_wdata = 32'h0008_0000;
    cyc();
    clear_in();
    chk("R10 fpscr", fpscr, 32'h0008_0000);

    // R9 fatal stop with vector base zero
    hold_spc = spc;
    vbr_wr = 1; vbr_wdata = 0; sr_wr = 1; sr_wdata = 0;
    cyc();
    clear_in();
    chk("R10 vbr", vbr, 0);
    exc_req = 1; exc_code = 12'h180; pc = 32'h0000_4000;
    cyc();
    clear_in();
    chk("R9 halt", {31'b0, halt}, 1);
    chk("R9 no redirect", {31'b0, redirect}, 0);
    chk("R9 busy", {31'b0, busy}, 1);
    chk("R9 spc kept", spc, hold_spc);
    chk("R9 event kept", {20'b0, exc_event}, 32'h160);
    irq_req = 1; sr_wr = 1; sr_wdata = 32'h1234_5678;
    cyc();
    clear_in();
    chk("R9 irq ignored", {31'b0, irq_ack}, 0);
    chk("R9 write ignored", sr, 0);
    chk("R9 still halted", {31'b0, halt}, 1);

    done = 1;
    finish_run();
  end
endmodule